// File: doc/BRIEF.md
# Stream-Ordered Engine Dispatcher

This block accepts work commands from a host-side command port and hands them to a small set of execution engines. Each command carries an operation code (upload copy, kernel, download copy), a stream number and a duration in cycles. The duration stands in for the real work, which this block does not perform. Commands are queued in per-engine first-in-first-out queues. There is always one kernel engine. A parameter selects either a single copy engine that serves both copy directions, or two copy engines, one per direction.

An engine may start the command at the head of its queue only when every command issued earlier to the same stream has finished, whichever engine ran it. Stream 0 acts as a synchronising stream. It waits for the whole device to drain before its command is taken, and it holds off every later command until it completes. Because each queue is strictly first-in-first-out, the order in which the host issues commands decides whether work in one stream can overlap work in another. The host watches one idle bit per stream and one device-wide idle bit.

Top module: `stream_dispatch`

## Requirements
- R1: A command starts only after all commands previously issued to its stream have completed, even when they ran on other engines; completions within one stream occur in issue order.
- R2: Each engine starts its queued commands strictly in arrival order; a later entry whose stream is ready still waits behind a blocked head.
- R3: Operation code 0 is an upload copy, 1 a kernel, 2 a download copy, and 3 is handled as a kernel. With the dual-copy setting, uploads go to engine 0, kernels to engine 1 and downloads to engine 2. With the single-copy setting, both copy directions share engine 0 and run one after the other.
- R4: A command accepted while its engine is free and its stream is ready pulses that engine's completion bit, together with the stream number, exactly max(duration,1) cycles after the accepting clock edge.
- R5: A stream-0 command is accepted only when the device is idle. While a stream-0 command is outstanding, `cmd_ready` is low for every command.
- R6: `stream_idle[s]` is high exactly when every command accepted for stream s has completed.
- R7: `device_idle` is high only when all streams are idle.
- R8: `cmd_ready` is low when the queue targeted by the presented command holds its full depth; commands bound for other engines are still accepted.
- R9: After reset, all streams and the device report idle, no completion pulses, and `cmd_ready` is high for a non-default command.
- R10: Commands of different streams on different engines run at the same time, without delaying each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command presented |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 2 | Operation code (see R3) |
| cmd_stream | input | SID_W | Stream number, 0 is the synchronising stream |
| cmd_dur | input | DUR_W | Work duration in cycles, 0 treated as 1 |
| done_pulse | output | NUM_ENG | One-cycle completion pulse per engine |
| done_stream | output | NUM_ENG*SID_W | Stream of the completing command, one field per engine |
| stream_idle | output | NUM_STREAMS | Per-stream all-complete status |
| device_idle | output | 1 | All streams complete |

## Verification
On every cycle, the embedded properties check several local behaviours. Queues never overflow or underflow. A running engine holds its stream until it completes. No stream ever sees two completions at once, and no completion arrives on an idle stream. Nothing but stream 0 starts while a stream-0 command is outstanding, and stream 0 starts only when all other streams are idle. The device never reports idle with an engine busy.

Other behaviours depend on issue order across engines, so only the bench scenarios can show them. These are the exact latency, the head-of-line blocking that differs between one and two copy engines, the completion order across engines within a stream, and the overlap of independent streams. The bench checks them by comparing completion times and order against a per-stream scoreboard.

// File: rtl/sdisp_pkg.sv
package sdisp_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        OP_UPLOAD   = 2'd0,
        OP_KERNEL   = 2'd1,
        OP_DOWNLOAD = 2'd2,
        OP_ALTKERN  = 2'd3
    } op_e;

    localparam logic [1:0] ENG_COPY_UP   = 2'd0;
    localparam logic [1:0] ENG_KERN      = 2'd1;
    localparam logic [1:0] ENG_COPY_DOWN = 2'd2;

    function automatic int engine_count(bit dual);
        return dual ? 3 : 2;
    endfunction

    function automatic logic [1:0] engine_of(op_e op, bit dual);
        logic [1:0] eng;
        case (op)
            OP_UPLOAD:   eng = ENG_COPY_UP;
            OP_DOWNLOAD: eng = dual ? ENG_COPY_DOWN : ENG_COPY_UP;
            default:     eng = ENG_KERN;
        endcase
        return eng;
    endfunction
endpackage

// File: rtl/sdisp_queue.sv
module sdisp_queue #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign rdata = slots[rd_ptr];

    function automatic logic [PTR_W-1:0] advance(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= advance(wr_ptr);
            if (pop)  rd_ptr <= advance(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/sdisp_engine.sv
module sdisp_engine #(
    parameter int NS    = 8,
    parameter int SID_W = 3,
    parameter int SEQ_W = 7,
    parameter int DUR_W = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [SID_W-1:0] push_sid,
    input  logic [SEQ_W-1:0] push_seq,
    input  logic [DUR_W-1:0] push_dur,
    output logic             full,
    input  logic [SEQ_W-1:0] done_cnt [NS],
    output logic             start,
    output logic [SID_W-1:0] start_sid,
    output logic             busy,
    output logic             done,
    output logic [SID_W-1:0] done_sid
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [SID_W-1:0] sid;
        logic [SEQ_W-1:0] seq;
        logic [DUR_W-1:0] dur;
    } entry_t;
    localparam int ENTRY_W = $bits(entry_t);

    entry_t             wr_entry, head;
    logic [ENTRY_W-1:0] head_raw;
    logic               empty;
    logic               deps_met;
    logic [SID_W-1:0]   run_sid;
    logic [DUR_W-1:0]   remain;

    assign wr_entry = '{sid: push_sid, seq: push_seq, dur: push_dur};
    assign head     = entry_t'(head_raw);

    sdisp_queue #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) queue_i (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata (wr_entry),
        .full  (full),
        .pop   (start),
        .rdata (head_raw),
        .empty (empty)
    );

    // head may go only when its stream has retired every earlier command
    assign deps_met  = (done_cnt[head.sid] == head.seq);
    assign start     = !busy && !empty && deps_met;
    assign start_sid = head.sid;
    assign done      = busy && (remain == DUR_W'(1));
    assign done_sid  = run_sid;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            run_sid <= '0;
            remain  <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            run_sid <= head.sid;
            remain  <= (head.dur == '0) ? DUR_W'(1) : head.dur;
        end else if (busy) begin
            if (remain == DUR_W'(1)) busy <= 1'b0;
            else                     remain <= remain - DUR_W'(1);
        end
    end

    assert_run_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && $stable(run_sid)));
    assert_gap_after_done_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    assert_short_run_R4: assert property (@(posedge clk) disable iff (rst)
        (start && (head.dur <= DUR_W'(1))) |=> done);
endmodule

// File: rtl/sdisp_tracker.sv
module sdisp_tracker #(
    parameter int NS    = 8,
    parameter int SID_W = 3,
    parameter int SEQ_W = 7,
    parameter int NE    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [SID_W-1:0] issue_sid,
    input  logic [NE-1:0]    done_vec,
    input  logic [SID_W-1:0] done_sid [NE],
    output logic [SEQ_W-1:0] issue_seq,
    output logic [SEQ_W-1:0] done_cnt [NS],
    output logic [NS-1:0]    stream_idle,
    output logic             device_idle
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [SEQ_W-1:0] iss_cnt [NS];

    assign issue_seq   = iss_cnt[issue_sid];
    assign device_idle = &stream_idle;

    for (genvar s = 0; s < NS; s++) begin : g_stream
        logic [NE-1:0] hits;
        for (genvar e = 0; e < NE; e++) begin : g_eng
            assign hits[e] = done_vec[e] && (done_sid[e] == SID_W'(s));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                iss_cnt[s]  <= '0;
                done_cnt[s] <= '0;
            end else begin
                if (issue && (issue_sid == SID_W'(s))) iss_cnt[s] <= iss_cnt[s] + SEQ_W'(1);
                if (|hits) done_cnt[s] <= done_cnt[s] + SEQ_W'(1);
            end
        end

        assign stream_idle[s] = (iss_cnt[s] == done_cnt[s]);

        assert_one_done_R1: assert property (@(posedge clk) disable iff (rst)
            $countones(hits) <= 1);
        assert_done_on_busy_stream_R6: assert property (@(posedge clk) disable iff (rst)
            (|hits) |-> !stream_idle[s]);
    end
endmodule

// File: rtl/stream_dispatch.sv
module stream_dispatch
    import sdisp_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int QUEUE_DEPTH = 16,
    parameter int DUR_W       = 8,
    parameter bit DUAL_COPY   = 1'b1,
    localparam int SID_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int NUM_ENG    = DUAL_COPY ? 3 : 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [1:0]               cmd_op,
    input  logic [SID_W-1:0]         cmd_stream,
    input  logic [DUR_W-1:0]         cmd_dur,
    output logic [NUM_ENG-1:0]       done_pulse,
    output logic [NUM_ENG*SID_W-1:0] done_stream,
    output logic [NUM_STREAMS-1:0]   stream_idle,
    output logic                     device_idle
);
    timeunit 1ns;
    timeprecision 1ps;

    // enough headroom for every command a stream can have in flight
    localparam int SEQ_W = $clog2(NUM_ENG * (QUEUE_DEPTH + 1) + 1) + 1;

    logic [1:0]       tgt;
    logic             tgt_full;
    logic             accept;
    logic             default_open;
    logic [SEQ_W-1:0] issue_seq;
    logic [SEQ_W-1:0] done_cnt [NUM_STREAMS];
    logic [NUM_ENG-1:0] eng_full, eng_start, eng_busy, eng_push;
    logic [SID_W-1:0] eng_start_sid [NUM_ENG];
    logic [SID_W-1:0] eng_done_sid  [NUM_ENG];
    logic             others_idle;

    assign tgt = engine_of(op_e'(cmd_op), DUAL_COPY);

    always_comb begin
        tgt_full = 1'b0;
        for (int e = 0; e < NUM_ENG; e++) begin
            if (tgt == 2'(e)) tgt_full = eng_full[e];
        end
    end

    // synchronising stream: enters only on an empty device, then blocks all
    assign default_open = (cmd_stream != '0) || device_idle;
    assign cmd_ready    = !tgt_full && stream_idle[0] && default_open;
    assign accept       = cmd_valid && cmd_ready;

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        assign eng_push[e] = accept && (tgt == 2'(e));
        assign done_stream[e*SID_W +: SID_W] = eng_done_sid[e];

        sdisp_engine #(
            .NS(NUM_STREAMS), .SID_W(SID_W), .SEQ_W(SEQ_W),
            .DUR_W(DUR_W), .DEPTH(QUEUE_DEPTH)
        ) engine_i (
            .clk       (clk),
            .rst       (rst),
            .push      (eng_push[e]),
            .push_sid  (cmd_stream),
            .push_seq  (issue_seq),
            .push_dur  (cmd_dur),
            .full      (eng_full[e]),
            .done_cnt  (done_cnt),
            .start     (eng_start[e]),
            .start_sid (eng_start_sid[e]),
            .busy      (eng_busy[e]),
            .done      (done_pulse[e]),
            .done_sid  (eng_done_sid[e])
        );

        assert_default_barrier_R5: assert property (@(posedge clk) disable iff (rst)
            (eng_start[e] && (eng_start_sid[e] != '0)) |-> stream_idle[0]);
        assert_default_alone_R5: assert property (@(posedge clk) disable iff (rst)
            (eng_start[e] && (eng_start_sid[e] == '0)) |-> others_idle);
    end

    always_comb begin
        others_idle = 1'b1;
        for (int s = 1; s < NUM_STREAMS; s++) others_idle &= stream_idle[s];
    end

    sdisp_tracker #(
        .NS(NUM_STREAMS), .SID_W(SID_W), .SEQ_W(SEQ_W), .NE(NUM_ENG)
    ) tracker_i (
        .clk         (clk),
        .rst         (rst),
        .issue       (accept),
        .issue_sid   (cmd_stream),
        .done_vec    (done_pulse),
        .done_sid    (eng_done_sid),
        .issue_seq   (issue_seq),
        .done_cnt    (done_cnt),
        .stream_idle (stream_idle),
        .device_idle (device_idle)
    );

    assert_device_idle_R7: assert property (@(posedge clk) disable iff (rst)
        device_idle |-> (eng_busy == '0));

    if (DUAL_COPY) begin : g_dual_route
        assert_download_route_R3: assert property (@(posedge clk) disable iff (rst)
            eng_push[2] |-> (op_e'(cmd_op) == OP_DOWNLOAD));
    end
endmodule

// File: tb/stream_dispatch_tb_top.sv
module stream_dispatch_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    int cyc  = 0;
    int nchk = 0;
    int nerr = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic       cv [2];
    logic [1:0] cop [2];
    logic [2:0] cs [2];
    logic [7:0] cd [2];
    logic       rdy [2];
    logic       didle [2];
    logic [7:0] sidle0, sidle1;
    logic [2:0] done0;
    logic [8:0] dstr0;
    logic [1:0] done1;
    logic [5:0] dstr1;

    stream_dispatch #(.DUAL_COPY(1'b1)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cv[0]), .cmd_ready(rdy[0]),
        .cmd_op(cop[0]), .cmd_stream(cs[0]), .cmd_dur(cd[0]),
        .done_pulse(done0), .done_stream(dstr0),
        .stream_idle(sidle0), .device_idle(didle[0]));

    stream_dispatch #(.DUAL_COPY(1'b0)) dut_single_i (
        .clk(clk), .rst(rst), .cmd_valid(cv[1]), .cmd_ready(rdy[1]),
        .cmd_op(cop[1]), .cmd_stream(cs[1]), .cmd_dur(cd[1]),
        .done_pulse(done1), .done_stream(dstr1),
        .stream_idle(sidle1), .device_idle(didle[1]));

    // scoreboard: expected class per stream (0 upload, 1 kernel, 2 download)
    int exp_q [16][$];
    int t_done [2][8][3];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic retire(input int u, input int e, input int sid);
        int expc;
        int idx = u * 8 + sid;
        if (exp_q[idx].size() == 0) begin
            check(1'b0, "R1 completion with nothing pending", sid, -1);
            return;
        end
        expc = exp_q[idx].pop_front();
        if (u == 0) check(e == expc, "R3 engine of completion", e, expc);
        else check((e == 1) == (expc == 1), "R3 shared copy engine", e, expc);
        t_done[u][sid][expc] = cyc;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                for (int e = 0; e < 3; e++) if (done0[e]) retire(0, e, int'(dstr0[e*3 +: 3]));
                for (int e = 0; e < 2; e++) if (done1[e]) retire(1, e, int'(dstr1[e*3 +: 3]));
            end
        end
    end

    task automatic push(input int u, input int op, input int sid, input int dur,
                        output bit rdy_first, output int acc_t);
        @(negedge clk);
        cv[u] = 1'b1; cop[u] = 2'(op); cs[u] = 3'(sid); cd[u] = 8'(dur);
        #1;
        rdy_first = rdy[u];
        while (!rdy[u]) begin
            @(negedge clk);
            #1;
        end
        exp_q[u * 8 + sid].push_back((op == 3) ? 1 : op);
        @(posedge clk);
        @(negedge clk);
        acc_t = cyc;
        cv[u] = 1'b0;
    endtask

    task automatic wait_idle(input int u);
        do begin
            @(negedge clk);
            #1;
        end while (!didle[u]);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1 watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        bit r;
        int a1, a2, a3;
        for (int u = 0; u < 2; u++) begin
            cv[u] = 1'b0; cop[u] = 2'd0; cs[u] = 3'd1; cd[u] = 8'd1;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R9 reset state on both variants
        check(rdy[0] && rdy[1], "R9 ready after reset", int'(rdy[0]), 1);
        check(sidle0 == 8'hff && sidle1 == 8'hff, "R9 streams idle", int'(sidle0), 255);
        check(didle[0] && didle[1], "R9 device idle", int'(didle[0]), 1);
        check(done0 == '0 && done1 == '0, "R9 no completion", int'(done0), 0);

        // R4 latency, duration 0 treated as 1, code 3 as kernel
        push(0, 1, 5, 7, r, a1);
        wait_idle(0);
        check(t_done[0][5][1] - a1 == 7, "R4 latency dur 7", t_done[0][5][1] - a1, 7);
        push(0, 3, 5, 0, r, a1);
        wait_idle(0);
        check(t_done[0][5][1] - a1 == 1, "R4 R3 latency dur 0 code 3", t_done[0][5][1] - a1, 1);

        // R10 two streams on two engines overlap
        push(0, 0, 1, 20, r, a1);
        push(0, 1, 2, 20, r, a2);
        wait_idle(0);
        check(t_done[0][1][0] - a1 == 20, "R10 upload unaffected", t_done[0][1][0] - a1, 20);
        check(t_done[0][2][1] - a2 == 20, "R10 kernel concurrent", t_done[0][2][1] - a2, 20);

        // R3 shared copy engine serialises both directions
        push(1, 0, 1, 20, r, a1);
        push(1, 2, 2, 20, r, a2);
        wait_idle(1);
        check(t_done[1][2][2] >= t_done[1][1][0] + 20, "R3 single copy serial",
              t_done[1][2][2] - t_done[1][1][0], 20);

        // R2 head-of-line: depth-first issue on both variants
        for (int u = 0; u < 2; u++) begin
            for (int s = 1; s <= 2; s++) begin
                push(u, 0, s, 10, r, a1);
                push(u, 1, s, 10, r, a1);
                push(u, 2, s, 10, r, a1);
            end
            wait_idle(u);
            for (int s = 1; s <= 2; s++) begin
                check(t_done[u][s][1] > t_done[u][s][0], "R1 kernel after upload",
                      t_done[u][s][1], t_done[u][s][0] + 1);
                check(t_done[u][s][2] > t_done[u][s][1], "R1 download after kernel",
                      t_done[u][s][2], t_done[u][s][1] + 1);
            end
        end
        check(t_done[0][2][0] < t_done[0][1][2], "R2 dual engines avoid blocking",
              t_done[0][2][0], t_done[0][1][2] - 1);
        check(t_done[1][2][0] > t_done[1][1][2], "R2 shared queue blocks upload",
              t_done[1][2][0], t_done[1][1][2] + 1);

        // R5 synchronising stream
        push(0, 0, 1, 20, r, a1);
        push(0, 1, 0, 5, r, a2);
        check(r == 1'b0, "R5 stream 0 held while busy", int'(r), 0);
        push(0, 0, 2, 3, r, a3);
        check(r == 1'b0, "R5 later command held", int'(r), 0);
        wait_idle(0);
        check(t_done[0][0][1] > t_done[0][1][0], "R5 stream 0 after earlier work",
              t_done[0][0][1], t_done[0][1][0] + 1);
        check(t_done[0][2][0] > t_done[0][0][1], "R5 later work after stream 0",
              t_done[0][2][0], t_done[0][0][1] + 1);

        // R8 backpressure, R6 R7 status
        push(0, 1, 3, 150, r, a1);
        for (int i = 0; i < 16; i++) push(0, 1, 4, 1, r, a2);
        @(negedge clk);
        #1;
        check(sidle0[3] == 1'b0 && sidle0[4] == 1'b0, "R6 busy streams", int'(sidle0), 8'he7);
        check(sidle0[5] == 1'b1, "R6 untouched stream idle", int'(sidle0[5]), 1);
        check(didle[0] == 1'b0, "R7 device busy", int'(didle[0]), 0);
        push(0, 0, 6, 1, r, a2);
        check(r == 1'b1, "R8 other queue accepts", int'(r), 1);
        push(0, 1, 4, 1, r, a2);
        check(r == 1'b0, "R8 full kernel queue", int'(r), 0);
        wait_idle(0);
        check(sidle0 == 8'hff, "R6 all streams idle", int'(sidle0), 255);
        check(didle[0] == 1'b1, "R7 device idle again", int'(didle[0]), 1);
        for (int i = 0; i < 16; i++)
            check(exp_q[i].size() == 0, "R1 every command completed", exp_q[i].size(), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule